// File: doc/BRIEF.md
# Data-Processing ALU with Status Flags

This block is the arithmetic and logic stage of a 32-bit load/store processor core. Its inputs are a 4-bit operation code, the first source operand, and a second operand that the barrel shifter has already prepared, together with the shifter's carry-out. In the same cycle it produces the value for the destination register and a write strobe for that register. It also computes the next negative, zero, carry and overflow conditions. A small register stage inside the block holds those four condition flags and a sticky saturation flag.

The carry used by the carry-consuming operations enters on its own pin, so that the surrounding pipeline can supply either the architectural flag or a forwarded value. A saturating unit outside the block can raise the sticky flag. Only an explicit status write clears it. The adder is built from a parameterised number of equal chunks chained by their carries. A datapath module and a control module sit under the top and talk through one strobe struct.

Top module: `flag_alu`

## Requirements
- R1: The logical operation codes produce the following values. 0000 gives AND. 0001 gives exclusive OR. 1100 gives OR. 1110 gives bit clear, which is the first operand AND NOT the second. 1101 gives move, which passes the second operand through. 1111 gives move-not, which is the bitwise inverse of the second operand.
- R2: Code 0100 adds the two operands. Code 0010 subtracts the second operand from the first. Code 0011 subtracts the first operand from the second. Each result is taken modulo 2^32.
- R3: The carry-using forms take carryIn as C. Code 0101 gives first + second + C. Code 0110 gives first − second − NOT C. Code 0111 gives second − first − NOT C.
- R4: When the flags update, N takes result bit 31 and Z is 1 exactly when the result is zero.
- R5: When the flags update, C follows the operation class. Arithmetic operations take the adder carry-out, which for subtraction means 1 when no borrow occurs. Logical operations take shiftCarry.
- R6: When an arithmetic operation updates the flags, V is set on two's-complement signed overflow. Logical operations leave V unchanged.
- R7: The flag-only codes are 1000 (test: AND), 1001 (test-equivalence: exclusive OR), 1010 (compare: first − second) and 1011 (compare-negative: first + second). They never assert rdWrEn and always update the flags, whatever setFlags says. The result port still shows the computed value.
- R8: All other codes update N, Z, C and V only when setFlags is 1. No update of any kind happens while issue is 0, and rdWrEn equals issue for the codes that are not flag-only.
- R9: A 1 on satHit sets Q. Q then stays 1 through any number of operations until a status write clears it.
- R10: When statusWr is 1, the next clock loads {N,Z,C,V,Q} from statusWrData bits 4 down to 0. This load takes priority over any operation update or satHit in the same cycle.
- R11: While rstN is low, all five flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| issue | input | 1 | An operation executes this cycle |
| opcode | input | 4 | Operation code |
| rnVal | input | 32 | First source operand |
| op2Val | input | 32 | Shifted second operand |
| shiftCarry | input | 1 | Carry-out of the shifter |
| carryIn | input | 1 | Carry flag used by the carry-consuming operations |
| setFlags | input | 1 | Request to update the condition flags |
| satHit | input | 1 | Saturation event that sets Q |
| statusWr | input | 1 | Explicit status write |
| statusWrData | input | 5 | Value to write, {N,Z,C,V,Q} |
| result | output | 32 | Computed value |
| rdWrEn | output | 1 | Destination register write enable |
| flagN | output | 1 | Negative flag |
| flagZ | output | 1 | Zero flag |
| flagC | output | 1 | Carry flag |
| flagV | output | 1 | Overflow flag |
| flagQ | output | 1 | Sticky saturation flag |

## Verification
The bench builds the block with its default parameters: a width of 32 and an adder chunk of 8 bits. That gives four chained adder chunks. Operands such as 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF, mixed with random words, push carries across every chunk boundary and into the sign bit. Those operands therefore reach signed overflow and the borrow cases of every subtract form. Random setFlags, issue, satHit and status-write patterns cover the interaction between flag gating, sticky Q and write priority.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

  typedef enum logic [3:0] {
    OP_AND = 4'h0, OP_EOR = 4'h1, OP_SUB = 4'h2, OP_RSB = 4'h3,
    OP_ADD = 4'h4, OP_ADC = 4'h5, OP_SBC = 4'h6, OP_RSC = 4'h7,
    OP_TST = 4'h8, OP_TEQ = 4'h9, OP_CMP = 4'hA, OP_CMN = 4'hB,
    OP_ORR = 4'hC, OP_MOV = 4'hD, OP_BIC = 4'hE, OP_MVN = 4'hF
  } aluOp_e;

  typedef enum logic [2:0] {
    LG_AND, LG_EOR, LG_ORR, LG_BIC, LG_MOV, LG_MVN
  } logicOp_e;

  typedef enum logic [1:0] {
    CIN_ZERO, CIN_ONE, CIN_FLAG
  } carrySrc_e;

  // strobes from control to datapath and flag register
  typedef struct packed {
    logic      isArith;
    logic      invRn;
    logic      invOp2;
    carrySrc_e carrySrc;
    logicOp_e  logicOp;
    logic      rdWrite;
    logic      flagUpd;
  } aluCtrl_t;

endpackage

// File: rtl/flag_alu_ctrl.sv
module flag_alu_ctrl
  import flag_alu_pkg::*;
(
  input  logic     issue,
  input  logic     setFlags,
  input  logic [3:0] opcode,
  output aluCtrl_t ctrl
);

  logic flagOnly;

  always_comb begin
    ctrl          = '0;
    ctrl.carrySrc = CIN_ZERO;
    ctrl.logicOp  = LG_AND;
    flagOnly      = 1'b0;
    unique case (aluOp_e'(opcode))
      OP_AND: ctrl.logicOp = LG_AND;
      OP_EOR: ctrl.logicOp = LG_EOR;
      OP_ORR: ctrl.logicOp = LG_ORR;
      OP_BIC: ctrl.logicOp = LG_BIC;
      OP_MOV: ctrl.logicOp = LG_MOV;
      OP_MVN: ctrl.logicOp = LG_MVN;
      OP_TST: begin ctrl.logicOp = LG_AND; flagOnly = 1'b1; end
      OP_TEQ: begin ctrl.logicOp = LG_EOR; flagOnly = 1'b1; end
      OP_ADD: ctrl.isArith = 1'b1;
      OP_ADC: begin ctrl.isArith = 1'b1; ctrl.carrySrc = CIN_FLAG; end
      OP_SUB: begin ctrl.isArith = 1'b1; ctrl.invOp2 = 1'b1; ctrl.carrySrc = CIN_ONE; end
      OP_SBC: begin ctrl.isArith = 1'b1; ctrl.invOp2 = 1'b1; ctrl.carrySrc = CIN_FLAG; end
      OP_RSB: begin ctrl.isArith = 1'b1; ctrl.invRn = 1'b1; ctrl.carrySrc = CIN_ONE; end
      OP_RSC: begin ctrl.isArith = 1'b1; ctrl.invRn = 1'b1; ctrl.carrySrc = CIN_FLAG; end
      OP_CMP: begin
        ctrl.isArith = 1'b1; ctrl.invOp2 = 1'b1; ctrl.carrySrc = CIN_ONE; flagOnly = 1'b1;
      end
      OP_CMN: begin ctrl.isArith = 1'b1; flagOnly = 1'b1; end
      default: ctrl.logicOp = LG_AND;
    endcase
    ctrl.rdWrite = issue & ~flagOnly;
    ctrl.flagUpd = issue & (flagOnly | setFlags);
  end

endmodule

// File: rtl/flag_alu_dp.sv
module flag_alu_dp
  import flag_alu_pkg::*;
#(
  parameter int W     = 32,
  parameter int CHUNK = 8
) (
  input  aluCtrl_t       ctrl,
  input  logic [W-1:0]   rnVal,
  input  logic [W-1:0]   op2Val,
  input  logic           carryIn,
  input  logic           shiftCarry,
  output logic [W-1:0]   result,
  output logic           carryOut,
  output logic           ovf
);

  localparam int NCH = W / CHUNK;

  logic [W-1:0] opA, opB, sumVal, logicVal;
  logic [NCH:0] chain;
  logic         msbCarry;

  assign opA = ctrl.invRn  ? ~rnVal  : rnVal;
  assign opB = ctrl.invOp2 ? ~op2Val : op2Val;

  always_comb begin
    unique case (ctrl.carrySrc)
      CIN_ONE:  chain[0] = 1'b1;
      CIN_FLAG: chain[0] = carryIn;
      default:  chain[0] = 1'b0;
    endcase
  end

  // chunked adder, carries chained between equal slices
  for (genvar g = 0; g < NCH; g++) begin : g_chunk
    logic [CHUNK:0] part;
    assign part = {1'b0, opA[g*CHUNK +: CHUNK]} + {1'b0, opB[g*CHUNK +: CHUNK]}
                + (CHUNK+1)'(chain[g]);
    assign sumVal[g*CHUNK +: CHUNK] = part[CHUNK-1:0];
    assign chain[g+1] = part[CHUNK];
  end

  assign msbCarry = opA[W-1] ^ opB[W-1] ^ sumVal[W-1];

  always_comb begin
    unique case (ctrl.logicOp)
      LG_AND:  logicVal = rnVal & op2Val;
      LG_EOR:  logicVal = rnVal ^ op2Val;
      LG_ORR:  logicVal = rnVal | op2Val;
      LG_BIC:  logicVal = rnVal & ~op2Val;
      LG_MOV:  logicVal = op2Val;
      LG_MVN:  logicVal = ~op2Val;
      default: logicVal = '0;
    endcase
  end

  assign result   = ctrl.isArith ? sumVal : logicVal;
  assign carryOut = ctrl.isArith ? chain[NCH] : shiftCarry;
  assign ovf      = msbCarry ^ chain[NCH];

endmodule

// File: rtl/flag_alu_flags.sv
module flag_alu_flags
  import flag_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  aluCtrl_t     ctrl,
  input  logic [W-1:0] result,
  input  logic         carryOut,
  input  logic         ovf,
  input  logic         satHit,
  input  logic         statusWr,
  input  logic [4:0]   statusWrData,
  output logic         flagN,
  output logic         flagZ,
  output logic         flagC,
  output logic         flagV,
  output logic         flagQ
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      {flagN, flagZ, flagC, flagV, flagQ} <= '0;
    end else if (statusWr) begin
      {flagN, flagZ, flagC, flagV, flagQ} <= statusWrData;
    end else begin
      if (ctrl.flagUpd) begin
        flagN <= result[W-1];
        flagZ <= (result == '0);
        flagC <= carryOut;
        if (ctrl.isArith) flagV <= ovf;
      end
      if (satHit) flagQ <= 1'b1;
    end
  end

endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import flag_alu_pkg::*;
#(
  parameter int W     = 32,
  parameter int CHUNK = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         issue,
  input  logic [3:0]   opcode,
  input  logic [W-1:0] rnVal,
  input  logic [W-1:0] op2Val,
  input  logic         shiftCarry,
  input  logic         carryIn,
  input  logic         setFlags,
  input  logic         satHit,
  input  logic         statusWr,
  input  logic [4:0]   statusWrData,
  output logic [W-1:0] result,
  output logic         rdWrEn,
  output logic         flagN,
  output logic         flagZ,
  output logic         flagC,
  output logic         flagV,
  output logic         flagQ
);

  aluCtrl_t ctrl;
  logic     carryOut, ovf;

  flag_alu_ctrl u_ctrl (
    .issue(issue), .setFlags(setFlags), .opcode(opcode), .ctrl(ctrl)
  );

  flag_alu_dp #(.W(W), .CHUNK(CHUNK)) u_dp (
    .ctrl(ctrl), .rnVal(rnVal), .op2Val(op2Val), .carryIn(carryIn),
    .shiftCarry(shiftCarry), .result(result), .carryOut(carryOut), .ovf(ovf)
  );

  flag_alu_flags #(.W(W)) u_flags (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .result(result), .carryOut(carryOut),
    .ovf(ovf), .satHit(satHit), .statusWr(statusWr), .statusWrData(statusWrData),
    .flagN(flagN), .flagZ(flagZ), .flagC(flagC), .flagV(flagV), .flagQ(flagQ)
  );

  assign rdWrEn = ctrl.rdWrite;

endmodule

// File: rtl/flag_alu_chk.sv
module flag_alu_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rstN,
  input logic         issue,
  input logic [3:0]   opcode,
  input logic         setFlags,
  input logic         satHit,
  input logic         statusWr,
  input logic [4:0]   statusWrData,
  input logic [W-1:0] result,
  input logic         rdWrEn,
  input logic         flagN,
  input logic         flagZ,
  input logic         flagC,
  input logic         flagV,
  input logic         flagQ
);

  logic flagOnlyOp, willUpd;
  assign flagOnlyOp = (opcode[3:2] == 2'b10);
  assign willUpd    = issue && (flagOnlyOp || setFlags) && !statusWr;

  a_r7_no_dest_write: assert property (@(posedge clk) disable iff (!rstN)
    flagOnlyOp |-> !rdWrEn);

  a_r8_flags_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!willUpd && !statusWr) |=> $stable({flagN, flagZ, flagC, flagV}));

  a_r4_zero_flag: assert property (@(posedge clk) disable iff (!rstN)
    willUpd |=> (flagZ == ($past(result) == '0)));

  a_r4_neg_flag: assert property (@(posedge clk) disable iff (!rstN)
    willUpd |=> (flagN == $past(result[W-1])));

  a_r9_q_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (flagQ && !statusWr) |=> flagQ);

  a_r10_status_load: assert property (@(posedge clk) disable iff (!rstN)
    statusWr |=> ({flagN, flagZ, flagC, flagV, flagQ} == $past(statusWrData)));

endmodule

bind flag_alu flag_alu_chk #(.W(W)) u_chk (
  .clk(clk), .rstN(rstN), .issue(issue), .opcode(opcode), .setFlags(setFlags),
  .satHit(satHit), .statusWr(statusWr), .statusWrData(statusWrData),
  .result(result), .rdWrEn(rdWrEn), .flagN(flagN), .flagZ(flagZ),
  .flagC(flagC), .flagV(flagV), .flagQ(flagQ)
);

// File: tb/flag_alu_tb.sv
`timescale 1ns/1ps
module flag_alu_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        issue = 1'b0;
  logic [3:0]  opcode = '0;
  logic [31:0] rnVal = '0, op2Val = '0;
  logic        shiftCarry = 1'b0, carryIn = 1'b0, setFlags = 1'b0;
  logic        satHit = 1'b0, statusWr = 1'b0;
  logic [4:0]  statusWrData = '0;
  logic [31:0] result;
  logic        rdWrEn, flagN, flagZ, flagC, flagV, flagQ;

  int testsRun = 0;
  int testsFailed = 0;
  logic [4:0] expFlags = '0;

  always #10 clk = ~clk;

  flag_alu u_dut (
    .clk(clk), .rstN(rstN), .issue(issue), .opcode(opcode), .rnVal(rnVal),
    .op2Val(op2Val), .shiftCarry(shiftCarry), .carryIn(carryIn),
    .setFlags(setFlags), .satHit(satHit), .statusWr(statusWr),
    .statusWrData(statusWrData), .result(result), .rdWrEn(rdWrEn),
    .flagN(flagN), .flagZ(flagZ), .flagC(flagC), .flagV(flagV), .flagQ(flagQ)
  );

  // reference computed from the requirements with wide integer arithmetic
  function automatic void refAlu(input logic [3:0] op, input logic [31:0] a, b,
                                 input logic ci, sc, output logic [31:0] r,
                                 output logic co, vo, ar);
    longint sa = longint'($signed(a));
    longint sb = longint'($signed(b));
    longint ua = longint'({32'b0, a});
    longint ub = longint'({32'b0, b});
    longint nc = ci ? 64'sd0 : 64'sd1;
    longint cc = ci ? 64'sd1 : 64'sd0;
    longint sTrue = 0;
    ar = 1'b1; co = sc; vo = 1'b0; r = '0;
    case (op)
      4'h4, 4'hB: begin r = a + b;           co = (ua + ub) > 64'hFFFFFFFF;      sTrue = sa + sb; end
      4'h5:       begin r = a + b + 32'(ci); co = (ua + ub + cc) > 64'hFFFFFFFF; sTrue = sa + sb + cc; end
      4'h2, 4'hA: begin r = a - b;           co = ua >= ub;                      sTrue = sa - sb; end
      4'h6:       begin r = a - b - 32'(!ci); co = ua >= ub + nc;                sTrue = sa - sb - nc; end
      4'h3:       begin r = b - a;           co = ub >= ua;                      sTrue = sb - sa; end
      4'h7:       begin r = b - a - 32'(!ci); co = ub >= ua + nc;                sTrue = sb - sa - nc; end
      default: begin
        ar = 1'b0;
        case (op)
          4'h0, 4'h8: r = a & b;
          4'h1, 4'h9: r = a ^ b;
          4'hC: r = a | b;
          4'hD: r = b;
          4'hE: r = a & ~b;
          default: r = ~b;
        endcase
      end
    endcase
    if (ar) vo = (sTrue != longint'($signed(r)));
  endfunction

  task automatic check(input string tag, input logic [63:0] act, exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input string tag, input logic [3:0] op, input logic [31:0] a, b,
                      input logic sc, ci, sf, iss, sat, sw, input logic [4:0] swd);
    logic [31:0] r;
    logic co, vo, ar, flagOnly, upd;
    issue = iss; opcode = op; rnVal = a; op2Val = b; shiftCarry = sc; carryIn = ci;
    setFlags = sf; satHit = sat; statusWr = sw; statusWrData = swd;
    #1;
    refAlu(op, a, b, ci, sc, r, co, vo, ar);
    flagOnly = (op[3:2] == 2'b10);
    check({tag, " result"}, {31'b0, rdWrEn, result}, {31'b0, iss & ~flagOnly, r});
    upd = iss && (flagOnly || sf);
    if (sw) expFlags = swd;
    else begin
      if (upd) begin
        expFlags[4] = r[31];
        expFlags[3] = (r == 0);
        expFlags[2] = co;
        if (ar) expFlags[1] = vo;
      end
      if (sat) expFlags[0] = 1'b1;
    end
    @(negedge clk);
    check({tag, " flags NZCVQ"}, {59'b0, flagN, flagZ, flagC, flagV, flagQ}, {59'b0, expFlags});
  endtask

  function automatic logic [31:0] pickOperand();
    case ($urandom_range(0, 7))
      0: return 32'h0000_0000;
      1: return 32'h0000_0001;
      2: return 32'h7FFF_FFFF;
      3: return 32'h8000_0000;
      4: return 32'hFFFF_FFFF;
      default: return $urandom();
    endcase
  endfunction

  initial begin
    #(20ns * 200000);
    testsFailed++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    statusWr = 1'b1; statusWrData = 5'h1F;
    repeat (3) @(negedge clk);
    // R11: reset clears all flags even with a status write pending
    check("R11 reset", {59'b0, flagN, flagZ, flagC, flagV, flagQ}, 64'd0);
    statusWr = 1'b0;
    rstN = 1'b1;
    @(negedge clk);

    // R1 logical codes
    step("R1 AND", 4'h0, 32'hF0F0_1234, 32'h0FF0_FF00, 1, 0, 1, 1, 0, 0, 0);
    step("R1 BIC", 4'hE, 32'hFFFF_FFFF, 32'h0000_FFFF, 0, 0, 1, 1, 0, 0, 0);
    step("R1 MVN", 4'hF, 32'h1234_5678, 32'h0000_0000, 1, 0, 1, 1, 0, 0, 0);
    // R6: signed overflow on add, then logic keeps V
    step("R6 ADD ovf", 4'h4, 32'h7FFF_FFFF, 32'h1, 0, 0, 1, 1, 0, 0, 0);
    step("R6 EOR keeps V", 4'h1, 32'h5, 32'h5, 0, 0, 1, 1, 0, 0, 0);
    // R5: equal subtract gives Z=1 and C=1 (no borrow)
    step("R5 SUB equal", 4'h2, 32'h5, 32'h5, 0, 0, 1, 1, 0, 0, 0);
    step("R5 SUB borrow", 4'h2, 32'h0, 32'h1, 0, 0, 1, 1, 0, 0, 0);
    // R3: carry forms at both carry values
    step("R3 SBC c0", 4'h6, 32'h10, 32'h10, 0, 0, 1, 1, 0, 0, 0);
    step("R3 RSC c1", 4'h7, 32'h3, 32'h8, 0, 1, 1, 1, 0, 0, 0);
    step("R3 ADC wrap", 4'h5, 32'hFFFF_FFFF, 32'h0, 0, 1, 1, 1, 0, 0, 0);
    // R7: compare without setFlags still updates, no write
    step("R7 CMP", 4'hA, 32'h8000_0000, 32'h1, 0, 0, 0, 1, 0, 0, 0);
    step("R7 TST", 4'h8, 32'hF0, 32'h0F, 1, 0, 0, 1, 0, 0, 0);
    // R8: no setFlags, and issue low
    step("R8 ADD noS", 4'h4, 32'h0, 32'h0, 0, 0, 0, 1, 0, 0, 0);
    step("R8 idle CMN", 4'hB, 32'h0, 32'h0, 0, 0, 1, 0, 0, 0, 0);
    // R9: Q sticky over many ops
    step("R9 set Q", 4'hD, 32'h0, 32'h1, 0, 0, 1, 1, 1, 0, 0);
    step("R9 Q holds", 4'h2, 32'h1, 32'h1, 0, 0, 1, 1, 0, 0, 0);
    // R10: write beats same-cycle update and satHit
    step("R10 write priority", 4'hA, 32'h0, 32'h1, 0, 0, 1, 1, 1, 1, 5'b01010);
    step("R10 write all", 4'h0, 32'h0, 32'h0, 0, 0, 0, 0, 0, 1, 5'b10101);

    // R2 and mixed random traffic
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] op = 4'($urandom_range(0, 15));
      step("R2 random", op, pickOperand(), pickOperand(),
           1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
           ($urandom_range(0, 9) != 0), ($urandom_range(0, 19) == 0),
           ($urandom_range(0, 29) == 0), 5'($urandom()));
    end

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule